// File: doc/BRIEF.md
# Processor-side interrupt acknowledge gate

This block sits between the interrupt distributor and one processor. Each cycle it sees the single interrupt the distributor is currently offering (an identifier, a group bit and a valid flag). From this and a small set of control bits it decides whether to raise the interrupt request line towards the processor. The control bits are an enable per group, an acknowledge-control bit and a mode bit that selects grouped or ungrouped operation.

The block also answers reads of three identifier registers: the primary acknowledge register, the aliased acknowledge register and the highest-pending register. A read is requested for one cycle together with a register select and the security state of the access. The identifier or the spurious identifier is returned with a valid strobe on the following cycle.

A two-state read sequencer handles the returns. Its states are `RD_IDLE` (no answer presented) and `RD_REPLY` (answer presented). There are three transitions:
- accept: `RD_IDLE` to `RD_REPLY` on a request.
- chain: `RD_REPLY` to `RD_REPLY` on a request in the answering cycle.
- done: `RD_REPLY` to `RD_IDLE` with no request.

Top module: `ackif_ack_unit`

## Requirements
- R1: After reset and in every cycle where `rd_valid` is 0, `rd_data` holds the spurious identifier 1023 (all ones for the default 10-bit width), and `rd_valid` and `irq` are 0 after reset while nothing is forwarded.
- R2: In grouped mode (`grouping_on`=1), `irq` is 1 exactly when a forwarded interrupt is valid and its group is enabled. Group 0 is `fwd_grp`=0 and is gated by `en_g0`; group 1 is `fwd_grp`=1 and is gated by `en_g1`. This is combinational, with no clock delay.
- R3: In grouped mode with `ack_ctl`=0, a primary acknowledge read (`rd_sel`=0) returns the identifier only for an enabled group 0 interrupt. Otherwise, including any read with `en_g0`=0, it returns 1023, whatever the security state.
- R4: An aliased acknowledge read (`rd_sel`=1) in grouped mode returns the identifier only for an enabled group 1 interrupt. With `en_g1`=0 any such read returns 1023.
- R5: In grouped mode with `ack_ctl`=1, a non-secure (`rd_secure`=0) primary read returns the identifier only for an enabled group 1 interrupt. A group 0 interrupt gives 1023, and any read with `en_g1`=0 gives 1023.
- R6: In grouped mode with `ack_ctl`=1, a secure primary read returns the identifier of an interrupt of either group whose group is enabled. So with `en_g0`=0 and `en_g1`=1, group 0 is ignored and the read acts as the aliased register.
- R7: With `ack_ctl`=1 and `en_g1`=0, a secure aliased read always returns 1023.
- R8: A highest-pending read (`rd_sel`=2) returns the identifier only when the forwarded interrupt's group is enabled. A pending interrupt in a disabled group gives 1023.
- R9: In ungrouped mode (`grouping_on`=0), `en_g0` is the only enable, and `fwd_grp`, `en_g1`, `ack_ctl` and `rd_secure` have no effect. `irq` equals `fwd_valid` AND `en_g0`. Primary and highest-pending reads return the identifier when that holds and 1023 otherwise. Aliased reads return 1023.
- R10: The request inputs are sampled at the clock edge where `rd_req` is 1. `rd_valid` is 1 with the answer in the next cycle. Requests in consecutive cycles are each answered in the cycle after their own.
- R11: Select code 3 is reserved and always returns 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grouping_on | input | 1 | 1 = grouped mode, 0 = single-enable mode |
| en_g0 | input | 1 | Group 0 enable (the single enable in ungrouped mode) |
| en_g1 | input | 1 | Group 1 enable |
| ack_ctl | input | 1 | Acknowledge-control bit |
| fwd_valid | input | 1 | Distributor is forwarding an interrupt |
| fwd_id | input | ID_W | Identifier of the forwarded interrupt |
| fwd_grp | input | 1 | Group of the forwarded interrupt |
| rd_req | input | 1 | Read request, one cycle |
| rd_sel | input | 2 | 0 primary ack, 1 aliased ack, 2 highest pending, 3 reserved |
| rd_secure | input | 1 | 1 = secure access |
| irq | output | 1 | Interrupt request to the processor |
| rd_valid | output | 1 | Read answer valid |
| rd_data | output | ID_W | Read answer identifier |

## Verification
The assertions check the following on every cycle:
- `irq` is never raised without a forwarded interrupt, and stays low in ungrouped mode when the single enable is clear.
- Every request is answered in the next cycle, and an idle output reads spurious.
- The disabled-group reads that must return spurious do so: the primary read with group 0 off and acknowledge-control clear, the aliased read with group 1 off, the non-secure primary read under acknowledge-control, and the reserved code.

Only the bench scenarios show that the right identifier comes back when a read should succeed. They also show the secure primary read switching to group 1 behaviour when group 0 is off, and back-to-back reads each returning their own answer.

// File: rtl/ackif_pkg.sv
package ackif_pkg;

    typedef enum logic [1:0] {
        SEL_ACK   = 2'd0,
        SEL_ALIAS = 2'd1,
        SEL_PEND  = 2'd2,
        SEL_RSVD  = 2'd3
    } rd_sel_e;

    typedef enum logic {
        RD_IDLE  = 1'b0,
        RD_REPLY = 1'b1
    } rd_state_e;

endpackage

// File: rtl/ackif_gate.sv
// Qualifies the forwarded interrupt against the group enables.
module ackif_gate (
    input  logic grouping_on,
    input  logic en_g0,
    input  logic en_g1,
    input  logic fwd_valid,
    input  logic fwd_grp,
    output logic g0_live,
    output logic g1_live,
    output logic irq
);

    always_comb begin
        if (grouping_on) begin
            g0_live = fwd_valid & ~fwd_grp & en_g0;
            g1_live = fwd_valid &  fwd_grp & en_g1;
        end else begin
            // Single-enable mode: every interrupt counts as group 0.
            g0_live = fwd_valid & en_g0;
            g1_live = 1'b0;
        end
        irq = g0_live | g1_live;
    end

endmodule

// File: rtl/ackif_decode.sv
// Picks the identifier or the spurious code for one register read.
module ackif_decode #(
    parameter int ID_W = 10
) (
    input  logic [1:0]      sel,
    input  logic            secure,
    input  logic            ack_ctl,
    input  logic            grouping_on,
    input  logic            g0_live,
    input  logic            g1_live,
    input  logic [ID_W-1:0] fwd_id,
    output logic [ID_W-1:0] id_out
);
    import ackif_pkg::*;

    localparam logic [ID_W-1:0] SPUR_ID = {ID_W{1'b1}};

    logic    hit;
    rd_sel_e sel_e;

    assign sel_e = rd_sel_e'(sel);

    always_comb begin
        hit = 1'b0;
        unique case (sel_e)
            SEL_ACK: begin
                if (!grouping_on || !ack_ctl) hit = g0_live;
                else if (secure)              hit = g0_live | g1_live;
                else                          hit = g1_live;
            end
            SEL_ALIAS: hit = grouping_on & g1_live;
            SEL_PEND:  hit = g0_live | g1_live;
            SEL_RSVD:  hit = 1'b0;
        endcase
        id_out = hit ? fwd_id : SPUR_ID;
    end

endmodule

// File: rtl/ackif_fsm.sv
// Read sequencer: accept in RD_IDLE, answer in RD_REPLY, chain on back-to-back.
module ackif_fsm #(
    parameter int ID_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_req,
    input  logic [ID_W-1:0] id_in,
    output logic            rd_valid,
    output logic [ID_W-1:0] rd_data
);
    import ackif_pkg::*;

    localparam logic [ID_W-1:0] SPUR_ID = {ID_W{1'b1}};

    rd_state_e state_q, state_d;
    logic [ID_W-1:0] data_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE:  if (rd_req) state_d = RD_REPLY;   // accept
            RD_REPLY: state_d = rd_req ? RD_REPLY       // chain
                                       : RD_IDLE;       // done
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RD_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      data_q <= SPUR_ID;
        else if (rd_req) data_q <= id_in;
        else             data_q <= SPUR_ID;
    end

    assign rd_valid = (state_q == RD_REPLY);
    assign rd_data  = data_q;

    p_answer_next_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);
    p_no_stray_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rd_valid);
    p_idle_spur_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> rd_data == SPUR_ID);

endmodule

// File: rtl/ackif_ack_unit.sv
module ackif_ack_unit #(
    parameter int ID_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            grouping_on,
    input  logic            en_g0,
    input  logic            en_g1,
    input  logic            ack_ctl,
    input  logic            fwd_valid,
    input  logic [ID_W-1:0] fwd_id,
    input  logic            fwd_grp,
    input  logic            rd_req,
    input  logic [1:0]      rd_sel,
    input  logic            rd_secure,
    output logic            irq,
    output logic            rd_valid,
    output logic [ID_W-1:0] rd_data
);
    import ackif_pkg::*;

    localparam logic [ID_W-1:0] SPUR_ID = {ID_W{1'b1}};

    logic            g0_live, g1_live;
    logic [ID_W-1:0] pick_id;

    ackif_gate u_gate (
        .grouping_on (grouping_on),
        .en_g0       (en_g0),
        .en_g1       (en_g1),
        .fwd_valid   (fwd_valid),
        .fwd_grp     (fwd_grp),
        .g0_live     (g0_live),
        .g1_live     (g1_live),
        .irq         (irq)
    );

    p_irq_needs_fwd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> fwd_valid);
    p_single_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!grouping_on && !en_g0) |-> !irq);

    ackif_decode #(.ID_W(ID_W)) u_dec (
        .sel         (rd_sel),
        .secure      (rd_secure),
        .ack_ctl     (ack_ctl),
        .grouping_on (grouping_on),
        .g0_live     (g0_live),
        .g1_live     (g1_live),
        .fwd_id      (fwd_id),
        .id_out      (pick_id)
    );

    ackif_fsm #(.ID_W(ID_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_req   (rd_req),
        .id_in    (pick_id),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    p_primary_g0off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_sel == SEL_ACK && grouping_on && !ack_ctl && !en_g0)
        |=> rd_data == SPUR_ID);
    p_alias_g1off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_sel == SEL_ALIAS && !en_g1) |=> rd_data == SPUR_ID);
    p_ns_primary_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_sel == SEL_ACK && grouping_on && ack_ctl && !rd_secure && !en_g1)
        |=> rd_data == SPUR_ID);
    p_reserved_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_sel == SEL_RSVD) |=> rd_data == SPUR_ID);

endmodule

// File: tb/sim_ackif_ack_unit.sv
module sim_ackif_ack_unit;

    localparam int ID_W = 10;
    localparam logic [ID_W-1:0] SPUR = 10'd1023;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic grouping_on = 1'b1, en_g0 = 1'b0, en_g1 = 1'b0, ack_ctl = 1'b0;
    logic fwd_valid = 1'b0, fwd_grp = 1'b0;
    logic [ID_W-1:0] fwd_id = '0;
    logic rd_req = 1'b0, rd_secure = 1'b0;
    logic [1:0] rd_sel = 2'd0;
    logic irq, rd_valid;
    logic [ID_W-1:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ackif_ack_unit #(.ID_W(ID_W)) u0 (
        .clk(clk), .rst_n(rst_n), .grouping_on(grouping_on),
        .en_g0(en_g0), .en_g1(en_g1), .ack_ctl(ack_ctl),
        .fwd_valid(fwd_valid), .fwd_id(fwd_id), .fwd_grp(fwd_grp),
        .rd_req(rd_req), .rd_sel(rd_sel), .rd_secure(rd_secure),
        .irq(irq), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic setup(input logic grp_on, input logic e0, input logic e1,
                         input logic actl, input logic v, input logic g,
                         input int id);
        @(negedge clk);
        grouping_on = grp_on; en_g0 = e0; en_g1 = e1; ack_ctl = actl;
        fwd_valid = v; fwd_grp = g; fwd_id = ID_W'(id);
    endtask

    task automatic read_chk(input string req, input logic [1:0] sel,
                            input logic sec, input int exp);
        @(negedge clk);
        rd_sel = sel; rd_secure = sec; rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        chk({req, " valid"}, int'(rd_valid), 1);
        chk({req, " data"}, int'(rd_data), exp);
    endtask

    task automatic t_reset;
        chk("R1 reset valid", int'(rd_valid), 0);
        chk("R1 reset data", int'(rd_data), int'(SPUR));
        chk("R1 reset irq", int'(irq), 0);
    endtask

    task automatic t_irq;
        setup(1, 0, 1, 0, 1, 0, 12); #1 chk("R2 g0 off", int'(irq), 0);
        setup(1, 1, 1, 0, 1, 0, 12); #1 chk("R2 g0 on", int'(irq), 1);
        setup(1, 1, 0, 0, 1, 1, 12); #1 chk("R2 g1 off", int'(irq), 0);
        setup(1, 1, 1, 0, 1, 1, 12); #1 chk("R2 g1 on", int'(irq), 1);
        setup(1, 1, 1, 0, 0, 1, 12); #1 chk("R2 no fwd", int'(irq), 0);
    endtask

    task automatic t_ackctl0;
        setup(1, 1, 1, 0, 1, 0, 37); read_chk("R3 g0 on", 2'd0, 0, 37);
        setup(1, 0, 1, 0, 1, 0, 37); read_chk("R3 g0 off", 2'd0, 1, int'(SPUR));
        setup(1, 1, 1, 0, 1, 1, 37); read_chk("R3 g1 intr", 2'd0, 0, int'(SPUR));
        setup(1, 1, 1, 0, 1, 1, 99); read_chk("R4 g1 on", 2'd1, 0, 99);
        setup(1, 1, 0, 0, 1, 1, 99); read_chk("R4 g1 off", 2'd1, 1, int'(SPUR));
    endtask

    task automatic t_ackctl1;
        setup(1, 1, 1, 1, 1, 1, 99); read_chk("R5 ns g1", 2'd0, 0, 99);
        setup(1, 1, 0, 1, 1, 1, 99); read_chk("R5 ns g1 off", 2'd0, 0, int'(SPUR));
        setup(1, 1, 1, 1, 1, 0, 55); read_chk("R5 ns g0 intr", 2'd0, 0, int'(SPUR));
        setup(1, 1, 1, 1, 1, 0, 55); read_chk("R6 s g0", 2'd0, 1, 55);
        setup(1, 0, 1, 1, 1, 0, 55); read_chk("R6 s g0 ignored", 2'd0, 1, int'(SPUR));
        setup(1, 0, 1, 1, 1, 1, 66); read_chk("R6 s as alias", 2'd0, 1, 66);
        setup(1, 1, 0, 1, 1, 1, 66); read_chk("R7 s alias off", 2'd1, 1, int'(SPUR));
        setup(1, 1, 1, 1, 1, 1, 66); read_chk("R7 s alias on", 2'd1, 1, 66);
    endtask

    task automatic t_pending;
        setup(1, 0, 1, 0, 1, 0, 21); read_chk("R8 pend disabled", 2'd2, 0, int'(SPUR));
        setup(1, 1, 0, 0, 1, 0, 21); read_chk("R8 pend enabled", 2'd2, 0, 21);
        setup(1, 1, 0, 0, 1, 1, 22); read_chk("R8 pend g1 off", 2'd2, 1, int'(SPUR));
        setup(1, 1, 1, 0, 1, 1, 1);  read_chk("R11 reserved", 2'd3, 1, int'(SPUR));
    endtask

    task automatic t_ungrouped;
        setup(0, 1, 0, 1, 1, 1, 5);
        #1 chk("R9 irq on", int'(irq), 1);
        read_chk("R9 primary", 2'd0, 0, 5);
        read_chk("R9 pending", 2'd2, 1, 5);
        read_chk("R9 alias", 2'd1, 1, int'(SPUR));
        setup(0, 0, 1, 0, 1, 0, 5);
        #1 chk("R9 irq off", int'(irq), 0);
        read_chk("R9 primary off", 2'd0, 0, int'(SPUR));
    endtask

    task automatic t_b2b;
        setup(1, 1, 1, 0, 1, 0, 300);
        @(negedge clk);
        rd_sel = 2'd0; rd_secure = 1'b0; rd_req = 1'b1;
        @(negedge clk);
        rd_sel = 2'd1;
        chk("R10 first valid", int'(rd_valid), 1);
        chk("R10 first data", int'(rd_data), 300);
        @(negedge clk);
        rd_req = 1'b0;
        chk("R10 second valid", int'(rd_valid), 1);
        chk("R10 second data", int'(rd_data), int'(SPUR));
        @(negedge clk);
        chk("R10 idle valid", int'(rd_valid), 0);
        chk("R1 idle data", int'(rd_data), int'(SPUR));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_irq();
        t_ackctl0();
        t_ackctl1();
        t_pending();
        t_ungrouped();
        t_b2b();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule